// File: doc/BRIEF.md
# Masked Vector Byte Permute Unit

This unit assembles a destination vector byte by byte. Each destination element carries its own index byte, and that index names the byte of the data vector to be copied there. The datapath is always 512 bits wide. A length select picks how much of it is live: 128, 256 or 512 bits. Only the low index bits that address the live length are used. Any live destination byte may pick any live source byte, and one source byte may be copied to many destinations.

A per-byte write mask sits after the selection and can be turned on or off. When it is on, an element whose mask bit is clear either keeps the caller's old destination byte (merge) or becomes zero (zeroing), as set by a mode flag. Every byte above the live length comes out as zero whatever the mask, index or old value says. The result is captured in an output register, with a valid flag one cycle behind the input valid.

Top module: `vbyte_permute_unit`

## Requirements
- R1: `len_sel` sets the live length: 2'b00 gives 16 bytes (128 bits), 2'b01 gives 32 bytes (256 bits), and both 2'b10 and 2'b11 give 64 bytes (512 bits).
- R2: Destination byte j takes the data byte whose number is the low 4, 5 or 6 bits of index byte j, for 16, 32 or 64 live bytes. The index byte sits at bits [8j+7:8j] of `index_vec`. Its higher bits have no effect.
- R3: One data byte may feed several destinations. A destination may select any live data byte, including bytes far from its own position.
- R4: When `mask_on` is 0, or when bit j of `byte_mask` is 1, live destination byte j is the selected data byte.
- R5: When `mask_on` is 1, bit j of `byte_mask` is 0 and `zero_fill` is 1, live destination byte j is 0x00.
- R6: When `mask_on` is 1, bit j of `byte_mask` is 0 and `zero_fill` is 0, live destination byte j equals byte j of `prior_vec`.
- R7: Every destination byte at or above the live length is 0x00.
- R8: Bits of `byte_mask` at or above the live length have no effect on `result_vec`.
- R9: `result_valid` equals `in_valid` of the previous clock. `result_vec` loads only on a cycle with `in_valid` high and otherwise holds its value.
- R10: While `rst_n` is low at a clock edge, `result_valid` and `result_vec` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs hold an operation this cycle |
| len_sel | input | 2 | Live vector length code |
| index_vec | input | 512 | One index byte per destination element |
| data_vec | input | 512 | Bytes to pick from |
| prior_vec | input | 512 | Old destination value, used for merging |
| byte_mask | input | 64 | Per-element write mask |
| mask_on | input | 1 | Apply `byte_mask` when 1 |
| zero_fill | input | 1 | Masked-off elements become zero when 1, keep the old value when 0 |
| result_valid | output | 1 | `result_vec` holds a new result |
| result_vec | output | 512 | Registered destination vector |

## Verification
A wrong length decode shows up as nonzero bytes above the live length. It also shows up as the wrong source byte wherever an index has bits set above the live width. Either error appears in the `result_vec` sampled one clock after the operation. A fault in a crossbar select or in the merge choice corrupts particular destination bytes of that same result. Merge, zeroing and pass-through are driven under differing mask patterns, so each of the three paths is seen at the ports. A fault in the output register shows on the next idle cycle, as a value that changes or a valid that does not fall.

// File: rtl/vbp_pkg.sv
// Package: shared constants and the length-code type for the byte permute unit.
// Assumes byte-wide elements and a maximum width that is a power of two.
package vbp_pkg;

    localparam int unsigned VBP_BYTE_W    = 8;
    localparam int unsigned VBP_MAX_BYTES = 64;

    // Live length codes; both upper codes select the full width.
    typedef enum logic [1:0] {
        LEN_QUARTER = 2'b00,
        LEN_HALF    = 2'b01,
        LEN_FULL    = 2'b10,
        LEN_FULL_B  = 2'b11
    } len_code_e;

    // Right shift applied to the maximum byte count for a length code.
    function automatic int unsigned len_shift(input logic [1:0] code);
        case (code)
            LEN_QUARTER: len_shift = 2;
            LEN_HALF:    len_shift = 1;
            default:     len_shift = 0;
        endcase
    endfunction

endpackage

// File: rtl/vbp_len_decode.sv
// Module: turns the length code into an index keep-mask and a per-element
// live flag. Assumes NUM_BYTES is a power of two, at least 4.
module vbp_len_decode
    import vbp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = VBP_MAX_BYTES,
    localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
    input  logic [1:0]           len_sel,
    output logic [IDX_W-1:0]     idx_keep,
    output logic [NUM_BYTES-1:0] elem_live
);

    int unsigned live_count;

    // Purpose: live element count and the matching index keep-mask.
    always_comb begin
        live_count = NUM_BYTES >> len_shift(len_sel);
        idx_keep   = IDX_W'(live_count - 1);
    end

    // One live flag per element: set below the live count.
    for (genvar j = 0; j < NUM_BYTES; j++) begin : g_live
        assign elem_live[j] = (j < live_count);
    end

endmodule

// File: rtl/vbp_byte_xbar.sv
// Module: full byte crossbar. Each destination element drives its own
// NUM_BYTES-to-1 byte multiplexer. The select is the element's index byte
// with the bits above the live width cleared. Assumes NUM_BYTES <= 128.
module vbp_byte_xbar
    import vbp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = VBP_MAX_BYTES,
    localparam int unsigned IDX_W    = $clog2(NUM_BYTES),
    localparam int unsigned VEC_W    = NUM_BYTES * VBP_BYTE_W
) (
    input  logic [VEC_W-1:0] index_vec,
    input  logic [VEC_W-1:0] data_vec,
    input  logic [IDX_W-1:0] idx_keep,
    output logic [VEC_W-1:0] picked_vec
);

    logic [VBP_BYTE_W-1:0] data_b [NUM_BYTES];

    // Unpack the data vector into an addressable byte array.
    for (genvar s = 0; s < NUM_BYTES; s++) begin : g_unpack
        assign data_b[s] = data_vec[s*VBP_BYTE_W +: VBP_BYTE_W];
    end

    for (genvar j = 0; j < NUM_BYTES; j++) begin : g_lane
        logic [VBP_BYTE_W-1:0] raw_idx;
        logic [IDX_W-1:0]      sel;
        logic                  unused_idx_hi;

        assign raw_idx       = index_vec[j*VBP_BYTE_W +: VBP_BYTE_W];
        assign unused_idx_hi = ^raw_idx[VBP_BYTE_W-1:IDX_W];

        // Purpose: clear index bits above the live width, then select.
        always_comb begin
            sel = raw_idx[IDX_W-1:0] & idx_keep;
            picked_vec[j*VBP_BYTE_W +: VBP_BYTE_W] = data_b[sel];
        end
    end

endmodule

// File: rtl/vbp_merge.sv
// Module: per-element write-mask stage. It passes the picked byte, keeps
// the prior byte or writes zero. Elements outside the live length are zero.
// Assumes elem_live is a thermometer code from the length decoder.
module vbp_merge
    import vbp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = VBP_MAX_BYTES,
    localparam int unsigned VEC_W    = NUM_BYTES * VBP_BYTE_W
) (
    input  logic [VEC_W-1:0]     picked_vec,
    input  logic [VEC_W-1:0]     prior_vec,
    input  logic [NUM_BYTES-1:0] byte_mask,
    input  logic                 mask_on,
    input  logic                 zero_fill,
    input  logic [NUM_BYTES-1:0] elem_live,
    output logic [VEC_W-1:0]     merged_vec
);

    for (genvar j = 0; j < NUM_BYTES; j++) begin : g_elem
        logic write_en;

        assign write_en = !mask_on || byte_mask[j];

        // Purpose: choose the byte for element j.
        always_comb begin
            if (!elem_live[j]) begin
                merged_vec[j*VBP_BYTE_W +: VBP_BYTE_W] = '0;
            end else if (write_en) begin
                merged_vec[j*VBP_BYTE_W +: VBP_BYTE_W] = picked_vec[j*VBP_BYTE_W +: VBP_BYTE_W];
            end else if (zero_fill) begin
                merged_vec[j*VBP_BYTE_W +: VBP_BYTE_W] = '0;
            end else begin
                merged_vec[j*VBP_BYTE_W +: VBP_BYTE_W] = prior_vec[j*VBP_BYTE_W +: VBP_BYTE_W];
            end
        end
    end

endmodule

// File: rtl/vbp_out_reg.sv
// Module: result register with valid flag and synchronous active-low reset.
// The data loads only on a valid cycle.
module vbp_out_reg #(
    parameter int unsigned VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] next_vec,
    output logic             result_valid,
    output logic [VEC_W-1:0] result_vec
);

    // Purpose: track the input valid with one cycle of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) result_valid <= 1'b0;
        else        result_valid <= in_valid;
    end

    // Purpose: capture the merged vector on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)        result_vec <= '0;
        else if (in_valid) result_vec <= next_vec;
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);
    a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !result_valid);
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_vec));

endmodule

// File: rtl/vbyte_permute_unit.sv
// Module: top of the masked byte permute unit. Index bytes pick data bytes
// across the live length. A write mask merges or zeroes elements. The
// result is registered. Assumes NUM_BYTES is a power of two, 4 to 128.
module vbyte_permute_unit
    import vbp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = VBP_MAX_BYTES,
    localparam int unsigned IDX_W    = $clog2(NUM_BYTES),
    localparam int unsigned VEC_W    = NUM_BYTES * VBP_BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           len_sel,
    input  logic [VEC_W-1:0]     index_vec,
    input  logic [VEC_W-1:0]     data_vec,
    input  logic [VEC_W-1:0]     prior_vec,
    input  logic [NUM_BYTES-1:0] byte_mask,
    input  logic                 mask_on,
    input  logic                 zero_fill,
    output logic                 result_valid,
    output logic [VEC_W-1:0]     result_vec
);

    logic [IDX_W-1:0]     idx_keep;
    logic [NUM_BYTES-1:0] elem_live;
    logic [VEC_W-1:0]     picked_vec;
    logic [VEC_W-1:0]     merged_vec;

    vbp_len_decode #(.NUM_BYTES(NUM_BYTES)) u_len (
        .len_sel   (len_sel),
        .idx_keep  (idx_keep),
        .elem_live (elem_live)
    );

    vbp_byte_xbar #(.NUM_BYTES(NUM_BYTES)) u_xbar (
        .index_vec  (index_vec),
        .data_vec   (data_vec),
        .idx_keep   (idx_keep),
        .picked_vec (picked_vec)
    );

    vbp_merge #(.NUM_BYTES(NUM_BYTES)) u_merge (
        .picked_vec (picked_vec),
        .prior_vec  (prior_vec),
        .byte_mask  (byte_mask),
        .mask_on    (mask_on),
        .zero_fill  (zero_fill),
        .elem_live  (elem_live),
        .merged_vec (merged_vec)
    );

    vbp_out_reg #(.VEC_W(VEC_W)) u_oreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .next_vec     (merged_vec),
        .result_valid (result_valid),
        .result_vec   (result_vec)
    );

    // Element 0 checks, at the ports, for the three write choices.
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel[1] && !mask_on) |=>
        result_vec[7:0] == $past(data_vec[{index_vec[IDX_W-1:0], 3'b000} +: 8]));
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_on && !byte_mask[0] && zero_fill) |=> result_vec[7:0] == 8'h00);
    a_r6_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_on && !byte_mask[0] && !zero_fill) |=>
        result_vec[7:0] == $past(prior_vec[7:0]));
    // R7: bytes above the live length are zero.
    a_r7_quarter_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel == LEN_QUARTER) |=> result_vec[VEC_W-1:VEC_W/4] == '0);
    a_r7_half_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel == LEN_HALF) |=> result_vec[VEC_W-1:VEC_W/2] == '0);
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!result_valid && result_vec == '0));

endmodule

// File: tb/test_vbyte_permute_unit.sv
module test_vbyte_permute_unit;

    localparam int NB = 64;
    localparam int VW = NB * 8;

    typedef struct packed {
        logic [1:0] vl;
        logic       men;
        logic       zm;
        logic       rep;
        logic [7:0] seed;
    } row_t;

    // Stimulus rows: length code, mask on, zero fill, repeated index, seed.
    localparam row_t ROWS [14] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{2'd1, 1'b0, 1'b0, 1'b0, 8'd5},
        '{2'd2, 1'b0, 1'b0, 1'b0, 8'd7},
        '{2'd3, 1'b0, 1'b0, 1'b0, 8'd9},
        '{2'd0, 1'b1, 1'b1, 1'b0, 8'd11},
        '{2'd1, 1'b1, 1'b1, 1'b0, 8'd13},
        '{2'd2, 1'b1, 1'b1, 1'b0, 8'd17},
        '{2'd0, 1'b1, 1'b0, 1'b0, 8'd19},
        '{2'd1, 1'b1, 1'b0, 1'b0, 8'd23},
        '{2'd2, 1'b1, 1'b0, 1'b0, 8'd29},
        '{2'd3, 1'b1, 1'b0, 1'b0, 8'd31},
        '{2'd2, 1'b0, 1'b0, 1'b1, 8'd37},
        '{2'd1, 1'b1, 1'b0, 1'b1, 8'd41},
        '{2'd0, 1'b0, 1'b1, 1'b1, 8'd43}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    len_sel;
    logic [VW-1:0] index_vec, data_vec, prior_vec;
    logic [NB-1:0] byte_mask;
    logic          mask_on, zero_fill;
    logic          result_valid;
    logic [VW-1:0] result_vec;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vbyte_permute_unit i_vbyte_permute_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .len_sel      (len_sel),
        .index_vec    (index_vec),
        .data_vec     (data_vec),
        .prior_vec    (prior_vec),
        .byte_mask    (byte_mask),
        .mask_on      (mask_on),
        .zero_fill    (zero_fill),
        .result_valid (result_valid),
        .result_vec   (result_vec)
    );

    function automatic int live_of(input logic [1:0] vl);
        return (vl == 2'd0) ? 16 : (vl == 2'd1) ? 32 : 64;
    endfunction

    // Expected result, written from R1 to R8.
    function automatic logic [VW-1:0] expect_vec(input logic [1:0] vl, input logic [VW-1:0] idx,
        input logic [VW-1:0] src, input logic [VW-1:0] old, input logic [NB-1:0] msk,
        input logic men, input logic zm);
        logic [VW-1:0] r;
        int n;
        int id;
        n = live_of(vl);
        r = '0;
        for (int j = 0; j < n; j++) begin
            id = int'(idx[j*8 +: 8]) % n;
            if (!men || msk[j])  r[j*8 +: 8] = src[id*8 +: 8];
            else if (zm)         r[j*8 +: 8] = 8'h00;
            else                 r[j*8 +: 8] = old[j*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] gen_idx(input int seed, input logic rep);
        logic [VW-1:0] v;
        for (int j = 0; j < NB; j++)
            v[j*8 +: 8] = rep ? 8'((seed * 5) | 8'hC0) : 8'(seed * 29 + j * (2 * seed + 1) + j * j * 3);
        return v;
    endfunction

    function automatic logic [VW-1:0] gen_data(input int seed, input int salt);
        logic [VW-1:0] v;
        for (int j = 0; j < NB; j++)
            v[j*8 +: 8] = 8'((j * 53 + seed * 11 + salt * 97) ^ salt) | 8'h01;
        return v;
    endfunction

    function automatic logic [NB-1:0] gen_mask(input int seed);
        logic [NB-1:0] m;
        for (int j = 0; j < NB; j++) m[j] = ((j * 7 + seed) % 3) != 0;
        return m;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // Drive one valid operation at a falling edge; sample at the next falling edge.
    task automatic run_op(input logic [1:0] vl, input logic [VW-1:0] idx, input logic [VW-1:0] src,
        input logic [VW-1:0] old, input logic [NB-1:0] msk, input logic men, input logic zm);
        in_valid  = 1'b1;
        len_sel   = vl;
        index_vec = idx;
        data_vec  = src;
        prior_vec = old;
        byte_mask = msk;
        mask_on   = men;
        zero_fill = zm;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] e, keep, idx, src;
        rst_n = 1'b0; in_valid = 1'b0; len_sel = 2'd2;
        index_vec = '0; data_vec = '0; prior_vec = '0;
        byte_mask = '0; mask_on = 1'b0; zero_fill = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R10 reset valid", result_valid, 1'b0);
        check_vec("R10 reset data", result_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 for each length, R4 R5 R6 by mode, R7 and R9 every row.
        foreach (ROWS[k]) begin
            idx = gen_idx(ROWS[k].seed, ROWS[k].rep);
            src = gen_data(ROWS[k].seed, 1);
            e = expect_vec(ROWS[k].vl, idx, src, gen_data(ROWS[k].seed, 2),
                           gen_mask(ROWS[k].seed), ROWS[k].men, ROWS[k].zm);
            run_op(ROWS[k].vl, idx, src, gen_data(ROWS[k].seed, 2),
                   gen_mask(ROWS[k].seed), ROWS[k].men, ROWS[k].zm);
            check_bit("R9 valid after op", result_valid, 1'b1);
            if (!ROWS[k].men)     check_vec("R4 R1 R2 R3 R7 pass row", result_vec, e);
            else if (ROWS[k].zm)  check_vec("R5 R1 R7 zero row", result_vec, e);
            else                  check_vec("R6 R1 R7 merge row", result_vec, e);
        end

        // R2: high index bits ignored at 32 bytes; element j takes byte (j^5)&31.
        src = gen_data(60, 3);
        for (int j = 0; j < NB; j++) idx[j*8 +: 8] = 8'((j ^ 5) | 8'hE0);
        run_op(2'd1, idx, src, '1, '0, 1'b0, 1'b0);
        e = '0;
        for (int j = 0; j < 32; j++) e[j*8 +: 8] = src[((j ^ 5) & 31)*8 +: 8];
        check_vec("R2 high index bits", result_vec, e);

        // R3: full-width reversal, byte 0 takes byte 63.
        for (int j = 0; j < NB; j++) idx[j*8 +: 8] = 8'(63 - j);
        run_op(2'd2, idx, src, '0, '0, 1'b0, 1'b0);
        e = '0;
        for (int j = 0; j < NB; j++) e[j*8 +: 8] = src[(63 - j)*8 +: 8];
        check_vec("R3 reversal", result_vec, e);

        // R8: 16 live bytes, mask bits 16..63 set, low 16 clear, zeroing -> all zero.
        run_op(2'd0, idx, src, '1, {{48{1'b1}}, 16'h0000}, 1'b1, 1'b1);
        check_vec("R8 upper mask ignored zero", result_vec, '0);
        // R8: same with merge -> low 16 bytes from prior, rest zero.
        run_op(2'd0, idx, src, gen_data(70, 4), {{48{1'b1}}, 16'h0000}, 1'b1, 1'b0);
        e = '0;
        e[127:0] = gen_data(70, 4) * 1'b1;
        e[VW-1:128] = '0;
        e[127:0] = gen_data(70, 4) >> 0;
        check_vec("R8 upper mask ignored merge", result_vec, {384'h0, e[127:0]});

        // R9: idle cycle with changed inputs holds the result and drops valid.
        keep = result_vec;
        len_sel = 2'd2; index_vec = gen_idx(77, 1'b0); data_vec = gen_data(77, 5);
        mask_on = 1'b0;
        @(negedge clk);
        check_bit("R9 idle valid low", result_valid, 1'b0);
        check_vec("R9 idle hold", result_vec, keep);

        // R10: reset after a result clears the register.
        run_op(2'd2, gen_idx(80, 1'b0), gen_data(80, 1), '0, '0, 1'b0, 1'b0);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check_bit("R10 mid reset valid", result_valid, 1'b0);
        check_vec("R10 mid reset data", result_vec, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule